// File: doc/BRIEF.md
# GPIO Port with Serial Pin Override

An eight-pin general-purpose I/O port that sits on a simple single-cycle register bus. Software programs a data latch and a direction mask. The block drives a per-pin output value and output enable to the pad logic. Pad input levels pass through a two-flop synchronizer before any other logic uses them.

Two serial peripherals can take over the low four pins. Each one claims a receive pin and a transmit pin. While a peripheral's enable is high, its transmit pin becomes an output carrying the peripheral's transmit bit, and its receive pin is released as an input. The port registers have no effect on claimed pins.

Reading the data address gives a per-bit mix: the latch where the pin is an output, and the synchronized pin level where it is an input. A separate read-only address always returns the synchronized level of all pins. Reset does not clear that value.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is low, and with no peripheral enabled, pad_oe_o and pad_out_o are all 0 and the direction address (1) reads 0.
- R2: A write to address 0 (data) updates the latch whatever the direction bits are, and a write to address 1 (direction) updates the direction mask; both take effect from the next clock edge.
- R3: On a pin no peripheral claims, pad_oe_o follows the direction bit (1 = output) and pad_out_o follows the data latch bit.
- R4: Reading address 0 returns, per bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R5: A change on pad_in_i shows in register reads after exactly two rising clock edges, and not after one.
- R6: Peripheral k claims pin 2k (receive) and pin 2k+1 (transmit). While ser_en_i[k] is 1, pin 2k+1 has output enable 1 and output value ser_tx_i[k], and pin 2k has output enable 0 and output value 0.
- R7: ser_rx_o[k] always carries the synchronized level of pin 2k.
- R8: Address 2 (pin input register) returns the synchronized levels of all pins, whatever the direction, data and enable settings. Writes to address 2 change neither the data register nor the direction register.
- R9: Address 3 is unmapped. It reads 0, and writes to it change no register.
- R10: Reset does not affect the pin input register. During reset, address 2 still returns the synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pad_in_i | input | 8 | Pad input levels, asynchronous |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 = drive |
| ser_en_i | input | 2 | Per-peripheral pin claim |
| ser_tx_i | input | 2 | Per-peripheral transmit bit |
| ser_rx_o | output | 2 | Per-peripheral synchronized receive bit |

## Verification
The latency properties assume that pad_in_i is sampled cleanly at each rising edge. They compare each read with the pin value from two edges earlier, which holds only when pins do not change at an edge. The bench therefore changes pins, enables and bus inputs only on the falling edge. The direction-write and ignored-write properties look only at pins above the claimed range, so they do not depend on how ser_en_i behaves. The stimulus keeps reset low for more than two edges, so that the synchronizer holds real pin values before any property is enabled.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_PIN  = 2;

  typedef enum logic [1:0] {
    PIN_PLAIN = 2'd0,
    PIN_RX    = 2'd1,
    PIN_TX    = 2'd2
  } pin_role_e;

  function automatic pin_role_e role_of(int pin, int n_ser);
    if (pin >= 2 * n_ser) return PIN_PLAIN;
    return (pin % 2 == 1) ? PIN_TX : PIN_RX;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
// Input synchronizer; deliberately not reset so it always tracks the pads
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o
);
  logic wr_data, wr_dir;

  assign wr_data = we_i && (addr_i == ADDR_W'(REG_DATA));
  assign wr_dir  = we_i && (addr_i == ADDR_W'(REG_DIR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      dir_o  <= '0;
    end else begin
      if (wr_data) data_o <= wdata_i;
      if (wr_dir)  dir_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int N_SER = 2
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [N_SER-1:0] ser_en_i,
  input  logic [N_SER-1:0] ser_tx_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam pin_role_e ROLE = role_of(i, N_SER);
    localparam int        SER  = i / 2;
    if (ROLE == PIN_TX) begin : g_tx
      assign pad_oe_o[i]  = ser_en_i[SER] | dir_i[i];
      assign pad_out_o[i] = ser_en_i[SER] ? ser_tx_i[SER] : data_i[i];
    end else if (ROLE == PIN_RX) begin : g_rx
      assign pad_oe_o[i]  = ~ser_en_i[SER] & dir_i[i];
      assign pad_out_o[i] = ~ser_en_i[SER] & data_i[i];
    end else begin : g_plain
      assign pad_oe_o[i]  = dir_i[i];
      assign pad_out_o[i] = data_i[i];
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  data_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] port_view;

  assign port_view = (data_i & dir_i) | (pin_i & ~dir_i);

  always_comb begin
    unique case (addr_i)
      ADDR_W'(REG_DATA): rdata_o = port_view;
      ADDR_W'(REG_DIR):  rdata_o = dir_i;
      ADDR_W'(REG_PIN):  rdata_o = pin_i;
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int N_SER       = 2,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o,
  input  logic [N_SER-1:0]  ser_en_i,
  input  logic [N_SER-1:0]  ser_tx_i,
  output logic [N_SER-1:0]  ser_rx_o
);
  logic [WIDTH-1:0] data_q, dir_q, pin_sync;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .data_o  (data_q),
    .dir_o   (dir_q)
  );

  gpio_pad_mux #(.WIDTH(WIDTH), .N_SER(N_SER)) u_pad (
    .data_i    (data_q),
    .dir_i     (dir_q),
    .ser_en_i  (ser_en_i),
    .ser_tx_i  (ser_tx_i),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  gpio_rd_mux #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (addr_i),
    .data_i  (data_q),
    .dir_i   (dir_q),
    .pin_i   (pin_sync),
    .rdata_o (rdata_o)
  );

  for (genvar k = 0; k < N_SER; k++) begin : g_rx
    assign ser_rx_o[k] = pin_sync[2*k];
  end
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int WIDTH  = 8,
  parameter int N_SER  = 2,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_in_i,
  input logic [WIDTH-1:0]  pad_out_o,
  input logic [WIDTH-1:0]  pad_oe_o,
  input logic [N_SER-1:0]  ser_en_i,
  input logic [N_SER-1:0]  ser_tx_i,
  input logic [N_SER-1:0]  ser_rx_o
);
  localparam int FREE_LO = 2 * N_SER;

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(3)) |-> (rdata_o == '0));

  assert_pin_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(2)) |-> (rdata_o == $past(pad_in_i, 2)));

  for (genvar k = 0; k < N_SER; k++) begin : g_ser
    assert_tx_override_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_en_i[k] |-> (pad_oe_o[2*k+1] && (pad_out_o[2*k+1] == ser_tx_i[k])));
    assert_rx_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_en_i[k] |-> (!pad_oe_o[2*k] && !pad_out_o[2*k]));
    assert_rx_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_rx_o[k] == $past(pad_in_i[2*k], 2));
  end

  for (genvar i = FREE_LO; i < WIDTH; i++) begin : g_free
    assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(1)) |=> (pad_oe_o[i] == $past(wdata_i[i])));
    assert_data_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(0)) |=> (pad_out_o[i] == $past(wdata_i[i])));
    assert_pin_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(2)) |=> ($stable(pad_oe_o[i]) && $stable(pad_out_o[i])));
  end
endmodule

bind gpio_ovr_port gpio_ovr_chk #(.WIDTH(WIDTH), .N_SER(N_SER), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_in_i  (pad_in_i),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .ser_en_i  (ser_en_i),
  .ser_tx_i  (ser_tx_i),
  .ser_rx_o  (ser_rx_o)
);

// File: tb/gpio_ovr_port_test.sv
`timescale 1ns/1ps
module gpio_ovr_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, pad_in_i, pad_out_o, pad_oe_o;
  logic [1:0] ser_en_i = '0, ser_tx_i = '0, ser_rx_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_data = '0, m_dir = '0;

  always #2 clk_i = ~clk_i;

  gpio_ovr_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
    .ser_en_i(ser_en_i), .ser_tx_i(ser_tx_i), .ser_rx_o(ser_rx_o)
  );

  function automatic logic [7:0] exp_oe(logic [7:0] d, logic [1:0] en);
    logic [7:0] r = d;
    for (int k = 0; k < 2; k++)
      if (en[k]) begin r[2*k+1] = 1'b1; r[2*k] = 1'b0; end
    return r;
  endfunction

  function automatic logic [7:0] exp_out(logic [7:0] dt, logic [1:0] en, logic [1:0] tx);
    logic [7:0] r = dt;
    for (int k = 0; k < 2; k++)
      if (en[k]) begin r[2*k+1] = tx[k]; r[2*k] = 1'b0; end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(logic [1:0] a, logic [7:0] pins);
    case (a)
      2'd0: return (m_data & m_dir) | (pins & ~m_dir);
      2'd1: return m_dir;
      2'd2: return pins;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd1) m_dir = d;
  endtask

  task automatic rd_check(string req, logic [1:0] a);
    @(negedge clk_i);
    addr_i = a;
    #0.5;
    check(req, rdata_o, exp_rd(a, pad_in_i));
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic pads_check(string req);
    #0.5;
    check({req, " oe"}, pad_oe_o, exp_oe(m_dir, ser_en_i));
    check({req, " out"}, pad_out_o, exp_out(m_data, ser_en_i, ser_tx_i));
    check({req, " rx"}, {6'd0, ser_rx_o}, {6'd0, pad_in_i[2], pad_in_i[0]});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    pad_in_i = 8'hA5;
    repeat (5) @(negedge clk_i);
    // R1, R10 during reset
    #0.5;
    check("R1 oe", pad_oe_o, 8'h00);
    check("R1 out", pad_out_o, 8'h00);
    addr_i = 2'd1; #0.5; check("R1 dir", rdata_o, 8'h00);
    addr_i = 2'd2; #0.5; check("R10 pin in reset", rdata_o, 8'hA5);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2, R3 preload in input mode
    wr(2'd0, 8'h3C);
    pads_check("R2 R3 preload");
    rd_check("R4 input mode", 2'd0);
    wr(2'd1, 8'hF0);
    pads_check("R3 dir");
    rd_check("R4 mixed", 2'd0);
    rd_check("R2 dir read", 2'd1);

    // R5 latency
    @(negedge clk_i); addr_i = 2'd2; pad_in_i = 8'h5A;
    @(posedge clk_i); #0.5; check("R5 one edge", rdata_o, 8'hA5);
    @(posedge clk_i); #0.5; check("R5 two edges", rdata_o, 8'h5A);

    // R6, R7
    @(negedge clk_i); ser_en_i = 2'b01; ser_tx_i = 2'b01; m_data = m_data;
    pads_check("R6 ser0");
    @(negedge clk_i); ser_en_i = 2'b11; ser_tx_i = 2'b10; pad_in_i = 8'hFF;
    settle(); pads_check("R6 R7 both");
    rd_check("R4 under override", 2'd0);

    // R8 write to input register ignored
    wr(2'd2, 8'h0F);
    rd_check("R8 data kept", 2'd0);
    rd_check("R8 dir kept", 2'd1);
    rd_check("R8 pins", 2'd2);

    // R9 unmapped
    wr(2'd3, 8'hFF);
    rd_check("R9 read zero", 2'd3);
    rd_check("R9 dir kept", 2'd1);
    pads_check("R9 pads kept");

    // R10 reset mid-run
    @(negedge clk_i); ser_en_i = '0; pad_in_i = 8'hC3;
    settle();
    rst_ni = 1'b0; m_data = '0; m_dir = '0;
    addr_i = 2'd2; #0.5; check("R10 pin kept", rdata_o, 8'hC3);
    pads_check("R1 reset again");
    @(negedge clk_i); rst_ni = 1'b1;

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      @(negedge clk_i);
      pad_in_i = 8'($urandom);
      ser_en_i = 2'($urandom);
      ser_tx_i = 2'($urandom);
      wr(a, 8'($urandom));
      settle();
      pads_check("R3 R6 R7 random");
      rd_check("R4 random", 2'd0);
      rd_check("R2 random", 2'd1);
      rd_check("R8 random", 2'd2);
      rd_check("R9 random", 2'd3);
    end

    done = 1;
    finish_run();
  end
endmodule